// File: doc/BRIEF.md
# Page-Mode Asynchronous Read Unit

This block models the read side of a word-wide flash array that keeps a four-word page open. A host presents an address, a chip select and an output gate, all active low. The first read from a page pays a long access latency. Once that read has finished, reads of the other three words in the same page pay only a short page latency. The word within the page is chosen by address bits [1:0], and these bits may be stepped in any order. Both latencies are counted in clock cycles and are set by parameters.

The unit drives a 16-bit data word, an enable for the external tristate buffer and a data-valid flag. It also reports standby while the chip is deselected. In addition it tracks an automatic low-power state. That state is entered after a read has completed and the pins then stay quiet. Any pin activity leaves the state again, and no extra latency is paid for it.

The array contents are a fixed function of the address, so that the read path can be checked without any storage behind it.

Top module: `pg_read_unit`

## Requirements
- R1: When a read completes, the returned word is addr_i[15:0] XOR 16'h5A3C, taken from the address that the read completed on.
- R2: data_oe_o is 1 only while ce_ni and oe_ni are both 0. data_o is 16'h0000 whenever data_oe_o is 0 or valid_o is 0.
- R3: A full-latency read is started by ce_ni falling, or by an address change to a word outside the open page. For such a read, valid_o rises on the FULL_LAT-th rising edge after the edge that first samples the new condition.
- R4: While a page is open, a change of only addr_i[1:0] raises valid_o on the PAGE_LAT-th rising edge after the edge that samples the change.
- R5: Page hits hold for any order of the word bits (for example 1, 3, 2, 0). Every such access costs PAGE_LAT.
- R6: A page opens when a read completes. A change in any of addr_i[ADDR_W-1:2] to a value other than the open page closes the page. The next completion then needs FULL_LAT.
- R7: With ce_ni at 1, standby_o is 1 from the next edge. valid_o and low_pwr_o are 0 from that edge, and the page is closed, so the next read costs FULL_LAT.
- R8: valid_o is 0 from the edge that samples any address change. Another change made before the count expires restarts the count.
- R9: low_pwr_o rises one edge after valid_o rises, provided the pins do not change and the unit is armed.
- R10: Any change of addr_i, ce_ni or oe_ni clears low_pwr_o at the next edge. An oe_ni toggle leaves valid_o at 1, so no latency is added.
- R11: After reset, with ce_ni held at 0, the unit is not armed. low_pwr_o stays 0 until the first address change or until ce_ni goes to 1.
- R12: During reset, valid_o and low_pwr_o are 0 and standby_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Word address |
| ce_ni | input | 1 | Chip select, active low |
| oe_ni | input | 1 | Output gate, active low |
| data_o | output | 16 | Read word (zero when not driven) |
| data_oe_o | output | 1 | Tristate enable for the data bus |
| valid_o | output | 1 | Read data valid |
| low_pwr_o | output | 1 | Automatic low-power state |
| standby_o | output | 1 | Deselected standby |

## Verification
The bench uses the default latencies of 9 and 3 cycles. Because the two values differ widely, a page hit and a page miss give clearly different completion times. There is also room to change the address part-way through an access, both before and after the short count would have expired. The 22-bit address lets the stimulus move between neighbouring pages and also flip high page bits, so the tag comparison is tested over its full width.

// File: rtl/pg_read_pkg.sv
package pg_read_pkg;
  localparam int unsigned DATA_W = 16;
  localparam logic [DATA_W-1:0] WORD_SALT = 16'h5A3C;

  function automatic logic [DATA_W-1:0] word_of(input logic [DATA_W-1:0] a);
    return a ^ WORD_SALT;
  endfunction
endpackage

// File: rtl/pg_page_tag.sv
module pg_page_tag #(
  parameter int unsigned TAG_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [TAG_W-1:0] tag_i,
  input  logic             clr_i,
  input  logic             load_i,
  output logic             hit_o
);
  logic [TAG_W-1:0] tag_q;
  logic             open_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tag_q  <= '0;
      open_q <= 1'b0;
    end else if (clr_i) begin
      open_q <= 1'b0;
    end else if (load_i) begin
      tag_q  <= tag_i;
      open_q <= 1'b1;
    end
  end

  assign hit_o = open_q && (tag_q == tag_i);
endmodule

// File: rtl/pg_lat_timer.sv
module pg_lat_timer #(
  parameter int unsigned FULL_LAT = 9,
  parameter int unsigned PAGE_LAT = 3,
  localparam int unsigned CNT_W = $clog2(FULL_LAT + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic fast_i,
  input  logic abort_i,
  output logic done_o,
  output logic valid_o
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(FULL_LAT);
  localparam logic [CNT_W-1:0] PAGE_CNT = CNT_W'(PAGE_LAT);
  localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             valid_q;

  assign done_o = !abort_i && !start_i && (cnt_q == ONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      valid_q <= 1'b0;
    end else if (abort_i) begin
      cnt_q   <= '0;
      valid_q <= 1'b0;
    end else if (start_i) begin
      cnt_q   <= fast_i ? PAGE_CNT : FULL_CNT;
      valid_q <= 1'b0;
    end else if (cnt_q > ONE) begin
      cnt_q   <= cnt_q - ONE;
    end else if (cnt_q == ONE) begin
      cnt_q   <= '0;
      valid_q <= 1'b1;
    end
  end

  assign valid_o = valid_q;
endmodule

// File: rtl/pg_lp_ctrl.sv
module pg_lp_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ce_ni,
  input  logic addr_chg_i,
  input  logic trans_i,
  input  logic valid_i,
  output logic lp_o
);
  logic armed_q;
  logic lp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      lp_q    <= 1'b0;
    end else if (ce_ni) begin
      armed_q <= 1'b1;
      lp_q    <= 1'b0;
    end else begin
      if (addr_chg_i) armed_q <= 1'b1;
      if (trans_i || !valid_i) lp_q <= 1'b0;
      else if (armed_q)        lp_q <= 1'b1;
    end
  end

  assign lp_o = lp_q;
endmodule

// File: rtl/pg_read_unit.sv
module pg_read_unit #(
  parameter int unsigned ADDR_W   = 22,
  parameter int unsigned FULL_LAT = 9,
  parameter int unsigned PAGE_LAT = 3
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [ADDR_W-1:0]              addr_i,
  input  logic                           ce_ni,
  input  logic                           oe_ni,
  output logic [pg_read_pkg::DATA_W-1:0] data_o,
  output logic                           data_oe_o,
  output logic                           valid_o,
  output logic                           low_pwr_o,
  output logic                           standby_o
);
  import pg_read_pkg::*;

  localparam int unsigned TAG_W = ADDR_W - 2;

  logic [ADDR_W-1:0] addr_q;
  logic              ce_q, oe_q, standby_q;
  logic [DATA_W-1:0] data_q;
  logic              addr_chg, trans, start, hit, done, rd_valid;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q    <= '0;
      ce_q      <= 1'b1;
      oe_q      <= 1'b1;
      standby_q <= 1'b1;
      data_q    <= '0;
    end else begin
      addr_q    <= addr_i;
      ce_q      <= ce_ni;
      oe_q      <= oe_ni;
      standby_q <= ce_ni;
      if (done) data_q <= word_of(addr_i[DATA_W-1:0]);
    end
  end

  assign addr_chg = addr_i != addr_q;
  assign trans    = addr_chg || (ce_ni != ce_q) || (oe_ni != oe_q);
  // new access: selected and either address moved or chip just selected
  assign start    = !ce_ni && (addr_chg || ce_q);

  pg_page_tag #(.TAG_W(TAG_W)) u_tag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tag_i  (addr_i[ADDR_W-1:2]),
    .clr_i  (ce_ni || (start && !hit)),
    .load_i (done),
    .hit_o  (hit)
  );

  pg_lat_timer #(.FULL_LAT(FULL_LAT), .PAGE_LAT(PAGE_LAT)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .fast_i  (hit),
    .abort_i (ce_ni),
    .done_o  (done),
    .valid_o (rd_valid)
  );

  pg_lp_ctrl u_lp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ce_ni      (ce_ni),
    .addr_chg_i (addr_chg),
    .trans_i    (trans),
    .valid_i    (rd_valid),
    .lp_o       (low_pwr_o)
  );

  assign data_oe_o = !ce_ni && !oe_ni;
  assign data_o    = (data_oe_o && rd_valid) ? data_q : '0;
  assign valid_o   = rd_valid;
  assign standby_o = standby_q;
endmodule

// File: rtl/pg_read_chk.sv
module pg_read_chk #(
  parameter int unsigned ADDR_W   = 22,
  parameter int unsigned FULL_LAT = 9,
  parameter int unsigned PAGE_LAT = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              ce_ni,
  input logic              oe_ni,
  input logic [15:0]       data_o,
  input logic              data_oe_o,
  input logic              valid_o,
  input logic              low_pwr_o,
  input logic              standby_o
);
  logic [ADDR_W-1:0] pa_q;
  logic              pce_q, poe_q;
  logic [15:0]       gap_q;
  logic              ev;

  assign ev = !ce_ni && ((addr_i != pa_q) || pce_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pa_q  <= '0;
      pce_q <= 1'b1;
      poe_q <= 1'b1;
      gap_q <= '0;
    end else begin
      pa_q  <= addr_i;
      pce_q <= ce_ni;
      poe_q <= oe_ni;
      if (ev)                gap_q <= 16'd1;
      else if (gap_q != '1)  gap_q <= gap_q + 16'd1;
    end
  end

  // R2
  bus_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_ni || oe_ni) |-> (!data_oe_o && data_o == '0));
  // R2
  data_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> data_o == '0);
  // R8
  addr_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_ni && addr_i != pa_q) |=> !valid_o);
  // R7
  standby_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_ni |=> (standby_o && !valid_o && !low_pwr_o));
  // R9
  lp_needs_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    low_pwr_o |-> (valid_o && !standby_o));
  // R3
  lat_max_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) |-> gap_q <= 16'(FULL_LAT + 1));
  // R4
  lat_min_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) |-> gap_q >= 16'(PAGE_LAT));
  // R10
  oe_wake_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (low_pwr_o && !ce_ni && !pce_q && addr_i == pa_q && oe_ni != poe_q)
      |=> (!low_pwr_o && valid_o));
endmodule

bind pg_read_unit pg_read_chk #(
  .ADDR_W(ADDR_W), .FULL_LAT(FULL_LAT), .PAGE_LAT(PAGE_LAT)
) u_chk (.*);

// File: tb/test_pg_read_unit.sv
module test_pg_read_unit;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 22;
  localparam int FL = 9;
  localparam int PL = 3;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic          ce_ni = 1'b0;
  logic          oe_ni = 1'b0;
  logic [15:0]   data_o;
  logic          data_oe_o, valid_o, low_pwr_o, standby_o;

  int n_chk = 0;
  int n_bad = 0;

  pg_read_unit #(.ADDR_W(AW), .FULL_LAT(FL), .PAGE_LAT(PL)) i_pg_read_unit (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  // behavioural reference state
  int          m_pa, m_cnt, m_tag;
  bit          m_pce, m_poe, m_open, m_valid, m_lp, m_armed, m_sb;
  logic [15:0] m_data;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_pa = 0; m_pce = 1; m_poe = 1; m_open = 0; m_cnt = 0; m_tag = 0;
      m_valid = 0; m_lp = 0; m_armed = 0; m_sb = 1; m_data = '0;
    end else begin
      int a;
      bit tr;
      a  = int'(addr_i);
      tr = (a != m_pa) || (ce_ni != m_pce) || (oe_ni != m_poe);
      if (ce_ni) begin
        m_open = 0; m_valid = 0; m_cnt = 0; m_lp = 0; m_armed = 1;
      end else if (a != m_pa || m_pce) begin
        bit h;
        h = m_open && (m_tag == (a >> 2));
        if (!h) m_open = 0;
        m_cnt = h ? PL : FL;
        m_valid = 0; m_lp = 0;
        if (a != m_pa) m_armed = 1;
      end else if (m_cnt > 1) begin
        m_cnt--;
      end else if (m_cnt == 1) begin
        m_cnt = 0; m_valid = 1; m_open = 1; m_tag = a >> 2;
        m_data = addr_i[15:0] ^ 16'h5A3C;
      end else if (m_valid) begin
        if (tr) m_lp = 0;
        else if (m_armed) m_lp = 1;
      end
      m_sb = ce_ni; m_pa = a; m_pce = ce_ni; m_poe = oe_ni;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison before new inputs are driven
  always @(negedge clk_i) begin
    if (rst_ni) begin
      bit oe_exp;
      oe_exp = !ce_ni && !oe_ni;
      check("R2 data_oe_o", 32'(data_oe_o), 32'(oe_exp));
      check("R1/R2 data_o", 32'(data_o), 32'((oe_exp && m_valid) ? m_data : 16'h0));
      check("R3/R8 valid_o", 32'(valid_o), 32'(m_valid));
      check("R9/R10 low_pwr_o", 32'(low_pwr_o), 32'(m_lp));
      check("R7 standby_o", 32'(standby_o), 32'(m_sb));
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      #1;
    end
  endtask

  // drive a new address and count negedges until valid_o is seen high
  task automatic lat_check(input string req, input logic [AW-1:0] a, input int lat);
    int n;
    addr_i = a;
    n = 0;
    for (int i = 0; i < 40; i++) begin
      step(1);
      n++;
      if (valid_o) break;
    end
    check(req, 32'(n), 32'(lat + 1));
  endtask

  initial begin
    step(2);
    check("R12 valid in reset", 32'(valid_o), 32'd0);
    check("R12 low_pwr in reset", 32'(low_pwr_o), 32'd0);
    check("R12 standby in reset", 32'(standby_o), 32'd1);
    rst_ni = 1'b1;
    // power-up with ce held low: full read, then no low power (R11)
    step(FL + 1);
    check("R3 first read valid", 32'(valid_o), 32'd1);
    check("R1 first word", 32'(data_o), 32'(16'h0000 ^ 16'h5A3C));
    step(4);
    check("R11 no low power before first address change", 32'(low_pwr_o), 32'd0);
    // page hits in scrambled order (R4, R5)
    lat_check("R4 hit word 1", 22'h000001, PL);
    step(1);
    check("R9 low power one edge after valid", 32'(low_pwr_o), 32'd1);
    lat_check("R5 hit word 3", 22'h000003, PL);
    lat_check("R5 hit word 2", 22'h000002, PL);
    lat_check("R5 hit word 0", 22'h000000, PL);
    // page miss (R6)
    lat_check("R6 neighbour page", 22'h000004, FL);
    lat_check("R4 hit in new page", 22'h000006, PL);
    lat_check("R6 high bit flip", 22'h200006, FL);
    check("R1 word after high flip", 32'(data_o), 32'(16'h0006 ^ 16'h5A3C));
    step(2);
    // oe toggle wakes with no latency (R10)
    check("R9 low power set", 32'(low_pwr_o), 32'd1);
    oe_ni = 1'b1;
    step(1);
    check("R10 low power cleared by oe", 32'(low_pwr_o), 32'd0);
    check("R10 valid held on oe toggle", 32'(valid_o), 32'd1);
    check("R2 bus released", 32'(data_oe_o), 32'd0);
    oe_ni = 1'b0;
    step(2);
    // deselect closes page (R7)
    ce_ni = 1'b1;
    step(2);
    check("R7 standby", 32'(standby_o), 32'd1);
    check("R7 valid low", 32'(valid_o), 32'd0);
    ce_ni = 1'b0;
    lat_check("R7 reselect pays full latency", 22'h200007, FL);
    // mid-access restart (R8)
    addr_i = 22'h000010;
    step(2);
    lat_check("R8 restart on change mid access", 22'h000011, FL);
    addr_i = 22'h000012;
    step(1);
    lat_check("R8 hit restart mid page access", 22'h000013, PL);
    // random phase checked against the model each cycle
    for (int k = 0; k < 3000; k++) begin
      int r;
      r = int'($urandom_range(0, 9));
      if (r < 5)       addr_i = {addr_i[AW-1:2], 2'($urandom_range(0, 3))};
      else if (r < 7)  addr_i = AW'($urandom_range(0, 15)) | (addr_i & 22'h300000);
      else if (r == 7) oe_ni = ~oe_ni;
      else if (r == 8) ce_ni = ($urandom_range(0, 3) == 0);
      else             addr_i[AW-1] = ~addr_i[AW-1];
      step(int'($urandom_range(1, 14)));
    end
    ce_ni = 1'b0;
    step(FL + 4);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired, actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule